// File: doc/BRIEF.md
# I2C Master Bit Timing Generator

This block is the bit-level engine of an I2C master. It runs from a single functional clock. It turns one-bit commands (START, repeated START, STOP, write a bit, read a bit) into open-drain enables for SCL and SDA. Every phase length is a programmable count, scaled by a power-of-two prescale value.

It watches the bus levels through a two-stage synchroniser and a glitch filter of programmable width, one for each line. Because of this, a slave that holds SCL low simply lengthens the high phase. When a command finishes, the block pulses a completion strobe and returns the SDA level it sampled.

The SCL high count is trimmed by the known input latency. The period of a data bit therefore follows a closed-form cycle count.

A higher layer supplies one command per handshake and shifts bytes through it. The layer keeps commands back-to-back by presenting the next command in the idle cycle that carries the strobe.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset, and whenever the block is idle with SCL released, both enables are 0 (line released), `cmd_ready` is 1 and `done` is 0. An enable of 1 pulls its line low.
- R2: With HI ≥ 1, a responsive bus and commands issued back-to-back, one data bit lasts (LO + HI + 2)·2^P + floor((2 + FS)/2^P) clock cycles, measured between successive rises of `scl_oe`. Here P is `cfg_prescale`, LO is `cfg_lo`, HI is `cfg_hi` and FS is `cfg_flt_scl`.
- R3: In a back-to-back data bit, `sda_oe` takes its new value max(2, (DV+1)·2^P) cycles after `scl_oe` rose, where DV is `cfg_dvd` and DV ≤ LO.
- R4: A write bit (op 3) drives `sda_oe` to the inverse of `cmd_wdata`. `sda_oe` holds that value through the SCL high phase and into the idle cycle that follows.
- R5: A read bit (op 4) releases SDA. It returns in `rdata` the filtered SDA level seen when filtered SCL is first high, and `rdata` is valid with `done`.
- R6: START (op 0) on a released bus holds SDA released for SH' = (SH+1)·2^P cycles, where SH is `cfg_sethold`. It then sets `sda_oe` and, SH' cycles later, sets `scl_oe`.
- R7: Repeated START (op 1) releases SDA after the data-valid delay of R3. It then releases SCL and waits for filtered SCL high plus SH' cycles before setting `sda_oe`. `scl_oe` is set SH' cycles after that.
- R8: STOP (op 2) pulls SDA low in the low phase and releases SCL. After filtered SCL is high plus SH', it releases SDA. `done` follows SH' cycles later, with both lines released.
- R9: The high count starts only when filtered SCL is high. After a slave releases a stretched SCL, `scl_oe` rises 3 + FS + H cycles later, where H = max(1, (HI+1)·2^P + floor((2+FS)/2^P) − 3 − FS). While SCL is held low, no completion is signalled.
- R10: With FS > 0, a level on SCL is accepted only after FS consecutive synchronised samples. A shorter pulse has no effect. FS = 0 bypasses the filter. `cfg_flt_sda` acts the same way on SDA.
- R11: `cmd_ready` is 1 only while idle, and a command is taken when `cmd_valid` and `cmd_ready` are both 1. `done` is a single-cycle pulse in the first idle cycle after completion. Op codes 5 to 7 act as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_prescale | input | PW | Power-of-two prescale P |
| cfg_lo | input | CW | SCL low count |
| cfg_hi | input | CW | SCL high count |
| cfg_sethold | input | CW | Setup/hold/bus-free count |
| cfg_dvd | input | CW | Data-valid delay count |
| cfg_flt_scl | input | FW | SCL glitch filter width |
| cfg_flt_sda | input | FW | SDA glitch filter width |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | 0 START, 1 repeated START, 2 STOP, 3 write, 4 read |
| cmd_wdata | input | 1 | Bit to write |
| cmd_ready | output | 1 | Idle, command accepted |
| done | output | 1 | Command complete strobe |
| rdata | output | 1 | Sampled SDA |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| scl_in | input | 1 | SCL bus level |
| sda_in | input | 1 | SDA bus level |

## Verification
Six timing sets are run through the same command sequence. They cover prescale values 0, 1 and 2, SCL filter widths 0 to 2, and high counts from 1 to 19. A wrong latency trim or a wrong prescale shift therefore shows up as a different bit period for some sets and not for others. Alternating write data makes SDA change in every bit, so the data-valid delay is measured each time. The two reads, one with the slave pulling low and one released, separate a real sample from a stuck value. Directed cases then hold SCL low for 100 cycles and inject a two-sample pulse under a filter width of 3. These cases separate a high count that waits for the bus from one that runs freely, and a filter that rejects short pulses from one that does not.

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer #(
  parameter int PW = 3,
  parameter int CW = 8,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] cfg_prescale,
  input  logic [CW-1:0] cfg_lo,
  input  logic [CW-1:0] cfg_hi,
  input  logic [CW-1:0] cfg_sethold,
  input  logic [CW-1:0] cfg_dvd,
  input  logic [FW-1:0] cfg_flt_scl,
  input  logic [FW-1:0] cfg_flt_sda,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic          cmd_wdata,
  output logic          cmd_ready,
  output logic          done,
  output logic          rdata,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          scl_in,
  input  logic          sda_in
);
  localparam int TW = CW + (1 << PW) + 2;
  localparam logic [2:0] OP_START = 3'd0, OP_RSTART = 3'd1, OP_STOP = 3'd2, OP_WRITE = 3'd3;

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_WAITH, S_HIGH, S_SETUP, S_HOLD, S_FREE} state_t;

  state_t        st;
  logic [TW-1:0] cnt;
  logic [2:0]    op_q;
  logic          wd_q;
  logic [1:0]    raw, line;

  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < 2; g++) begin : g_flt
    logic          s1, s2, fq;
    logic [FW-1:0] fc;
    logic [FW-1:0] w;
    assign w = (g == 0) ? cfg_flt_scl : cfg_flt_sda;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1; s2 <= 1'b1; fq <= 1'b1; fc <= '0;
      end else begin
        s1 <= raw[g];
        s2 <= s1;
        if (w == '0 || s2 == fq) begin
          fq <= s2; fc <= '0;
        end else if (fc == w - FW'(1)) begin
          fq <= s2; fc <= '0;
        end else begin
          fc <= fc + FW'(1);
        end
      end
    end
    assign line[g] = (w == '0) ? s2 : fq;
  end

  logic scl_f, sda_f;
  assign scl_f = line[0];
  assign sda_f = line[1];

  logic [TW-1:0] n_lo, n_dv, n_sh, hraw, lat, n_hi, lo_end, dv_raw, dv_at;
  assign n_lo   = (TW'(cfg_lo) + TW'(1)) << cfg_prescale;
  assign n_dv   = (TW'(cfg_dvd) + TW'(1)) << cfg_prescale;
  assign n_sh   = (TW'(cfg_sethold) + TW'(1)) << cfg_prescale;
  assign hraw   = ((TW'(cfg_hi) + TW'(1)) << cfg_prescale) + ((TW'(cfg_flt_scl) + TW'(2)) >> cfg_prescale);
  assign lat    = TW'(cfg_flt_scl) + TW'(3);
  assign n_hi   = (hraw > lat) ? hraw - lat : TW'(1);
  assign lo_end = (n_lo > TW'(2)) ? n_lo - TW'(2) : '0;
  assign dv_raw = (n_dv > TW'(2)) ? n_dv - TW'(2) : '0;
  assign dv_at  = (dv_raw > lo_end) ? lo_end : dv_raw;

  logic drv, is_ctl;
  assign is_ctl = (op_q <= OP_STOP);
  always_comb begin
    case (op_q)
      OP_STOP:  drv = 1'b1;
      OP_WRITE: drv = !wd_q;
      default:  drv = 1'b0;
    endcase
  end

  assign cmd_ready = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; op_q <= '0; wd_q <= 1'b0;
      done <= 1'b0; rdata <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          op_q <= cmd_op;
          wd_q <= cmd_wdata;
          cnt  <= '0;
          if ((cmd_op == OP_START || cmd_op == OP_RSTART) && !scl_oe) st <= S_SETUP;
          else st <= S_LOW;
        end
        S_LOW: begin
          cnt <= cnt + TW'(1);
          if (cnt == dv_at) sda_oe <= drv;
          if (cnt == lo_end) begin
            st <= S_WAITH; scl_oe <= 1'b0; cnt <= '0;
          end
        end
        S_WAITH: if (scl_f) begin
          cnt <= '0;
          if (is_ctl) st <= S_SETUP;
          else begin
            st <= S_HIGH; rdata <= sda_f;
          end
        end
        S_HIGH: begin
          cnt <= cnt + TW'(1);
          if (cnt == n_hi - TW'(1)) begin
            st <= S_IDLE; scl_oe <= 1'b1; done <= 1'b1;
          end
        end
        S_SETUP: begin
          cnt <= cnt + TW'(1);
          if (cnt == n_sh - TW'(1)) begin
            cnt <= '0;
            if (op_q == OP_STOP) begin
              sda_oe <= 1'b0; st <= S_FREE;
            end else begin
              sda_oe <= 1'b1; st <= S_HOLD;
            end
          end
        end
        S_HOLD: begin
          cnt <= cnt + TW'(1);
          if (cnt == n_sh - TW'(1)) begin
            st <= S_IDLE; scl_oe <= 1'b1; done <= 1'b1;
          end
        end
        S_FREE: begin
          cnt <= cnt + TW'(1);
          if (cnt == n_sh - TW'(1)) begin
            st <= S_IDLE; done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R11
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && cmd_ready) |=> !cmd_ready);
  // R9
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAITH && !scl_f) |=> (!scl_oe && !done));
  // R4
  sda_high_stable_chk: assert property (@(posedge clk) disable iff (!rst_n) (st == S_HIGH) |=> $stable(sda_oe));
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n) (st == S_IDLE && !scl_oe) |-> !sda_oe);
endmodule

// File: tb/i2c_bit_timer_tb.sv
module i2c_bit_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cfg_prescale = '0;
  logic [7:0] cfg_lo = 8'd11, cfg_hi = 8'd5, cfg_sethold = 8'd4, cfg_dvd = 8'd2;
  logic [3:0] cfg_flt_scl = '0, cfg_flt_sda = '0;
  logic cmd_valid = 1'b0, cmd_wdata = 1'b0;
  logic [2:0] cmd_op = '0;
  logic cmd_ready, done, rdata, scl_oe, sda_oe;
  logic stretch = 1'b0, slave_sda = 1'b0;
  wire scl_in = !(scl_oe || stretch);
  wire sda_in = !(sda_oe || slave_sda);

  i2c_bit_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_prescale(cfg_prescale), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .cfg_sethold(cfg_sethold), .cfg_dvd(cfg_dvd), .cfg_flt_scl(cfg_flt_scl), .cfg_flt_sda(cfg_flt_sda),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
    .done(done), .rdata(rdata), .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_in(scl_in), .sda_in(sda_in));

  always #10 clk = ~clk;

  int cyc = 0, t_scl_rise = 0, t_sda_rise = 0, t_sda_fall = 0, t_done = 0;
  logic p_scl = 1'b0, p_sda = 1'b0;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (scl_oe && !p_scl) t_scl_rise = cyc;
    if (sda_oe && !p_sda) t_sda_rise = cyc;
    if (!sda_oe && p_sda) t_sda_fall = cyc;
    if (done) t_done = cyc;
    p_scl = scl_oe;
    p_sda = sda_oe;
  end

  int nchk = 0, nfail = 0;
  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic issue(input logic [2:0] op, input logic wd);
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = wd;
  endtask

  task automatic wait_done();
    do step(); while (!done);
  endtask

  // P, FS, LO, HI, SH, DV, period, data-valid delay, setup/hold cycles
  localparam int VT [6][9] = '{
    '{0, 0, 11,  5,  4,  2,  20,  3,  5},
    '{2, 1, 17, 11,  7,  3, 120, 16, 32},
    '{0, 0,  3,  1,  2,  1,   8,  2,  3},
    '{1, 2,  7, 11,  7,  1,  42,  4, 16},
    '{0, 1, 24, 19, 29, 15,  48, 16, 30},
    '{0, 0,  5,  3,  2,  1,  12,  2,  3}
  };

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R11 watchdog: got no completion expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int r1, r2, r3, c, seen;
    step(); step();
    check("R1 reset scl_oe", int'(scl_oe), 0);
    check("R1 reset sda_oe", int'(sda_oe), 0);
    rst_n = 1'b1;
    step();
    check("R1 ready after reset", int'(cmd_ready), 1);
    check("R1 done after reset", int'(done), 0);

    for (int v = 0; v < 6; v++) begin
      cfg_prescale = 3'(VT[v][0]);
      cfg_flt_scl = 4'(VT[v][1]); cfg_flt_sda = 4'(VT[v][1]);
      cfg_lo = 8'(VT[v][2]); cfg_hi = 8'(VT[v][3]);
      cfg_sethold = 8'(VT[v][4]); cfg_dvd = 8'(VT[v][5]);
      step(); step();
      issue(3'd0, 1'b0); wait_done();
      check("R6 start hold", t_scl_rise - t_sda_rise, VT[v][8]);
      issue(3'd3, 1'b1); wait_done(); r1 = t_scl_rise;
      issue(3'd3, 1'b0); wait_done(); r2 = t_scl_rise;
      check("R3 data valid delay", t_sda_rise - r1, VT[v][7]);
      check("R4 write 0 pulls sda", int'(sda_oe), 1);
      issue(3'd3, 1'b1); wait_done();
      check("R2 bit period", t_scl_rise - r2, VT[v][6]);
      check("R4 write 1 releases sda", int'(sda_oe), 0);
      slave_sda = 1'b1;
      issue(3'd4, 1'b0); wait_done();
      check("R5 read low", int'(rdata), 0);
      slave_sda = 1'b0;
      issue(3'd4, 1'b0); wait_done();
      check("R5 read high", int'(rdata), 1);
      issue(3'd3, 1'b0); wait_done(); r3 = t_scl_rise;
      issue(3'd1, 1'b0); wait_done();
      check("R7 rstart sda release delay", t_sda_fall - r3, VT[v][7]);
      check("R7 rstart hold", t_scl_rise - t_sda_rise, VT[v][8]);
      issue(3'd2, 1'b0); wait_done(); cmd_valid = 1'b0;
      check("R8 stop bus free", t_done - t_sda_fall, VT[v][8]);
      check("R8 stop releases lines", int'({scl_oe, sda_oe}), 0);
    end

    // stretching, configuration of the first vector
    cfg_prescale = '0; cfg_flt_scl = '0; cfg_flt_sda = '0;
    cfg_lo = 8'd11; cfg_hi = 8'd5; cfg_sethold = 8'd4; cfg_dvd = 8'd2;
    step();
    issue(3'd0, 1'b0); wait_done();
    stretch = 1'b1;
    issue(3'd3, 1'b1);
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      step();
      if (done || cmd_ready) seen++;
    end
    check("R9 no completion while stretched", seen, 0);
    check("R11 busy while stretched", int'(cmd_ready), 0);
    check("R9 scl released while stretched", int'(scl_oe), 0);
    c = cyc; stretch = 1'b0;
    wait_done(); cmd_valid = 1'b0;
    check("R9 high count after stretch", t_scl_rise - c, 8);

    // glitch filter on SCL, width 3
    cfg_flt_scl = 4'd3;
    step();
    stretch = 1'b1;
    issue(3'd3, 1'b0);
    repeat (30) step();
    stretch = 1'b0; step(); step(); stretch = 1'b1;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (done) seen++;
    end
    check("R10 short pulse ignored", seen, 0);
    c = cyc; stretch = 1'b0;
    wait_done(); cmd_valid = 1'b0;
    check("R10 filtered release timing", t_scl_rise - c, 11);
    issue(3'd2, 1'b0); wait_done(); cmd_valid = 1'b0;
    check("R8 final stop releases lines", int'({scl_oe, sda_oe}), 0);
    step();
    check("R11 done is one cycle", int'(done), 0);
    check("R1 idle ready", int'(cmd_ready), 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule